// File: doc/BRIEF.md
# Privileged Operation Trap Decider

This block rules on a request for one of five privileged operations: the wait-for-interrupt instruction, the supervisor address-translation fence, the hypervisor virtual-address fence, the hypervisor guest-physical fence, and a read-only access to the entropy seed register. It looks at the current privilege level, the virtualization flag, the supervisor and hypervisor extension straps, and four trap-control status bits. From these it decides whether the operation goes ahead or traps. When it goes ahead, the block emits a halt request or a flush request. When it traps, the block emits an exception strobe with its cause code.

The decision is purely combinational. It is valid in the same cycle as the request strobe, so an execute stage can use it directly. The clock and reset feed only the embedded property checks. Halting the hart, the translation buffer contents and the seed register itself lie outside this block.

Top module: `privchk_top`

## Requirements
- R1: While `reqValid` is low, `doHalt`, `doFlush` and `raiseExc` are 0 and `excCause` is 0, whatever the other inputs are.
- R2: For a request, at most one of `doHalt`, `doFlush` and `raiseExc` is 1. `excCause` is 2 for illegal-instruction, 22 for virtual-instruction, and 0 when `raiseExc` is 0.
- R3: Wait (`reqOp`=0) is illegal in any of three cases: supervisor mode (`curPriv`=1) with `statTw` set; user mode (`curPriv`=0) with `statTw` set and `hasSup` clear; user mode with `hasSup` set and `virtMode` clear.
- R4: Wait that is not illegal under R3 raises virtual-instruction when `virtMode` is set and the hart is either in user mode or in supervisor mode with `statVtw` set. The illegal check wins over this one.
- R5: Wait that meets neither R3 nor R4 asserts `doHalt`. This includes every wait in machine mode (`curPriv`=2 or 3).
- R6: The supervisor fence (`reqOp`=1) is illegal in two cases: in user mode, or in supervisor mode with `statTvm` set. Otherwise it raises virtual-instruction when `hasHyp`, `virtMode` and `statVtvm` are all set. Otherwise it asserts `doFlush`.
- R7: The hypervisor virtual-address fence (`reqOp`=2) behaves as follows. In supervisor mode with `virtMode` set it raises virtual-instruction. In machine mode, or in supervisor mode with `virtMode` clear, it asserts `doFlush`. In user mode it is illegal.
- R8: The hypervisor guest-physical fence (`reqOp`=3) is illegal in supervisor mode when `virtMode` is clear and `statTvm` is set. Otherwise it follows R7.
- R9: A read-only seed access (`reqOp`=4) is illegal at every privilege level and in every mode.
- R10: Operation codes 5 to 7 are illegal. Privilege codes 2 and 3 both count as machine mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded property checks |
| rstN | input | 1 | Active-low reset, disables the checks |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 3 | Operation code (0 wait, 1 supervisor fence, 2 virtual-address fence, 3 guest-physical fence, 4 seed read) |
| curPriv | input | 2 | Current privilege (0 user, 1 supervisor, 2/3 machine) |
| virtMode | input | 1 | Hart is running virtualized |
| hasSup | input | 1 | Supervisor extension present |
| hasHyp | input | 1 | Hypervisor extension present |
| statTw | input | 1 | Trap wait-for-interrupt bit |
| statTvm | input | 1 | Trap translation-management bit |
| statVtw | input | 1 | Virtualized trap wait bit |
| statVtvm | input | 1 | Virtualized trap translation-management bit |
| doHalt | output | 1 | Halt request |
| doFlush | output | 1 | Translation flush request |
| raiseExc | output | 1 | Exception strobe |
| excCause | output | 5 | Exception cause code |

## Verification
The block holds no state, so a wrong internal decision shows at the ports in the same cycle the request is presented. A wrong decision can take three forms: a verdict swapped between execute and trap, a wrong cause code, or a strobe that leaks from one operation to another. The bench sweeps every combination of operation, privilege, mode, strap and status bit. This exposes any wrong priority between the illegal and virtual checks on the first vector that hits it.

// File: rtl/privchk_pkg.sv
package privchk_pkg;

  localparam int OP_W   = 3;
  localparam int PRIV_W = 2;

  localparam logic [OP_W-1:0] OP_WAIT     = 3'd0;
  localparam logic [OP_W-1:0] OP_SFENCE   = 3'd1;
  localparam logic [OP_W-1:0] OP_HFENCE_V = 3'd2;
  localparam logic [OP_W-1:0] OP_HFENCE_G = 3'd3;
  localparam logic [OP_W-1:0] OP_SEED_RO  = 3'd4;

  localparam logic [PRIV_W-1:0] PRIV_USER = 2'd0;
  localparam logic [PRIV_W-1:0] PRIV_SUP  = 2'd1;

  typedef enum logic [1:0] {
    VERD_EXEC    = 2'd0,
    VERD_ILLEGAL = 2'd1,
    VERD_VIRT    = 2'd2
  } verdict_e;

  typedef struct packed {
    logic haltStb;
    logic flushStb;
    logic illegalStb;
    logic virtStb;
  } ctrlStrobes_t;

endpackage

// File: rtl/privchk_ctrl.sv
module privchk_ctrl
  import privchk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [OP_W-1:0]   reqOp,
  input  logic [PRIV_W-1:0] curPriv,
  input  logic              virtMode,
  input  logic              hasSup,
  input  logic              hasHyp,
  input  logic              statTw,
  input  logic              statTvm,
  input  logic              statVtw,
  input  logic              statVtvm,
  output ctrlStrobes_t      strobes
);

  logic inUser, inSup, inMach;
  verdict_e waitVerd, sfenceVerd, hvaVerd, hgpaVerd, verdict;
  logic isFenceOp;

  // the top privilege bit alone marks machine mode (codes 2 and 3)
  assign inMach = curPriv[PRIV_W-1];
  assign inSup  = (curPriv == PRIV_SUP);
  assign inUser = (curPriv == PRIV_USER);

  // wait-for-interrupt: the illegal checks come before the virtual check
  always_comb begin
    waitVerd = VERD_EXEC;
    if ((inSup && statTw) ||
        (inUser && !hasSup && statTw) ||
        (inUser && hasSup && !virtMode)) begin
      waitVerd = VERD_ILLEGAL;
    end else if (virtMode && (inUser || (inSup && statVtw))) begin
      waitVerd = VERD_VIRT;
    end
  end

  // supervisor address-translation fence
  always_comb begin
    sfenceVerd = VERD_EXEC;
    if (inUser || (inSup && statTvm)) begin
      sfenceVerd = VERD_ILLEGAL;
    end else if (hasHyp && virtMode && statVtvm) begin
      sfenceVerd = VERD_VIRT;
    end
  end

  // hypervisor virtual-address fence
  always_comb begin
    if (inSup && virtMode) begin
      hvaVerd = VERD_VIRT;
    end else if (inMach || inSup) begin
      hvaVerd = VERD_EXEC;
    end else begin
      hvaVerd = VERD_ILLEGAL;
    end
  end

  // the guest-physical fence adds one illegal case and otherwise defers
  always_comb begin
    if (inSup && !virtMode && statTvm) begin
      hgpaVerd = VERD_ILLEGAL;
    end else begin
      hgpaVerd = hvaVerd;
    end
  end

  always_comb begin
    unique case (reqOp)
      OP_WAIT:     verdict = waitVerd;
      OP_SFENCE:   verdict = sfenceVerd;
      OP_HFENCE_V: verdict = hvaVerd;
      OP_HFENCE_G: verdict = hgpaVerd;
      default:     verdict = VERD_ILLEGAL;
    endcase
  end

  assign isFenceOp = (reqOp == OP_SFENCE) || (reqOp == OP_HFENCE_V) ||
                     (reqOp == OP_HFENCE_G);

  always_comb begin
    strobes = '0;
    if (reqValid) begin
      strobes.haltStb    = (verdict == VERD_EXEC) && (reqOp == OP_WAIT);
      strobes.flushStb   = (verdict == VERD_EXEC) && isFenceOp;
      strobes.illegalStb = (verdict == VERD_ILLEGAL);
      strobes.virtStb    = (verdict == VERD_VIRT);
    end
  end

  // R9
  seed_always_illegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == OP_SEED_RO) |-> (strobes.illegalStb && !strobes.haltStb));

  // R5
  mach_wait_halts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == OP_WAIT && curPriv[PRIV_W-1]) |-> strobes.haltStb);

  // R7
  virt_sup_hva_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == OP_HFENCE_V && curPriv == PRIV_SUP && virtMode) |-> strobes.virtStb);

  // R6
  user_sfence_illegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == OP_SFENCE && curPriv == PRIV_USER) |-> strobes.illegalStb);

endmodule

// File: rtl/privchk_dp.sv
module privchk_dp
  import privchk_pkg::*;
#(
  parameter int CAUSE_W       = 5,
  parameter int CAUSE_ILLEGAL = 2,
  parameter int CAUSE_VIRT    = 22
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  ctrlStrobes_t       strobes,
  output logic               doHalt,
  output logic               doFlush,
  output logic               raiseExc,
  output logic [CAUSE_W-1:0] excCause
);

  localparam logic [CAUSE_W-1:0] CodeIllegal = CAUSE_W'(CAUSE_ILLEGAL);
  localparam logic [CAUSE_W-1:0] CodeVirt    = CAUSE_W'(CAUSE_VIRT);

  assign doHalt   = strobes.haltStb;
  assign doFlush  = strobes.flushStb;
  assign raiseExc = strobes.illegalStb | strobes.virtStb;

  // illegal takes priority should both strobes ever rise together
  always_comb begin
    if (strobes.illegalStb) begin
      excCause = CodeIllegal;
    end else if (strobes.virtStb) begin
      excCause = CodeVirt;
    end else begin
      excCause = '0;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!doHalt && !doFlush && !raiseExc && excCause == '0));

  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({doHalt, doFlush, raiseExc}) <= 1);

  // R2
  cause_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    raiseExc |-> (excCause == CodeIllegal || excCause == CodeVirt));

  // R2
  cause_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !raiseExc |-> (excCause == '0));

endmodule

// File: rtl/privchk_top.sv
module privchk_top
  import privchk_pkg::*;
#(
  parameter int CAUSE_W       = 5,
  parameter int CAUSE_ILLEGAL = 2,
  parameter int CAUSE_VIRT    = 22
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [2:0]         reqOp,
  input  logic [1:0]         curPriv,
  input  logic               virtMode,
  input  logic               hasSup,
  input  logic               hasHyp,
  input  logic               statTw,
  input  logic               statTvm,
  input  logic               statVtw,
  input  logic               statVtvm,
  output logic               doHalt,
  output logic               doFlush,
  output logic               raiseExc,
  output logic [CAUSE_W-1:0] excCause
);

  ctrlStrobes_t strobes;

  privchk_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .curPriv  (curPriv),
    .virtMode (virtMode),
    .hasSup   (hasSup),
    .hasHyp   (hasHyp),
    .statTw   (statTw),
    .statTvm  (statTvm),
    .statVtw  (statVtw),
    .statVtvm (statVtvm),
    .strobes  (strobes)
  );

  privchk_dp #(
    .CAUSE_W       (CAUSE_W),
    .CAUSE_ILLEGAL (CAUSE_ILLEGAL),
    .CAUSE_VIRT    (CAUSE_VIRT)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobes  (strobes),
    .doHalt   (doHalt),
    .doFlush  (doFlush),
    .raiseExc (raiseExc),
    .excCause (excCause)
  );

endmodule

// File: tb/test_privchk_top.sv
`timescale 1ns/1ps
module test_privchk_top;

  localparam int RES_HALT  = 1;
  localparam int RES_FLUSH = 2;
  localparam int RES_ILL   = 3;
  localparam int RES_VIRT  = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, reqValid, virtMode, hasSup, hasHyp;
  logic statTw, statTvm, statVtw, statVtvm;
  logic [2:0] reqOp;
  logic [1:0] curPriv;
  logic doHalt, doFlush, raiseExc;
  logic [4:0] excCause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  privchk_top i_privchk_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .curPriv(curPriv), .virtMode(virtMode), .hasSup(hasSup), .hasHyp(hasHyp),
    .statTw(statTw), .statTvm(statTvm), .statVtw(statVtw), .statVtvm(statVtvm),
    .doHalt(doHalt), .doFlush(doFlush), .raiseExc(raiseExc), .excCause(excCause)
  );

  function automatic int hvRule(int pr, bit v);
    if (pr >= 2) return RES_FLUSH;
    if (pr == 1) return v ? RES_VIRT : RES_FLUSH;
    return RES_ILL;
  endfunction

  function automatic int refModel(int op, int pr, bit v, bit sup, bit hyp,
                                  bit tw, bit tvm, bit vtw, bit vtvm);
    case (op)
      0: begin
        if (pr >= 2) return RES_HALT;
        if (pr == 1) begin
          if (tw) return RES_ILL;
          if (v && vtw) return RES_VIRT;
          return RES_HALT;
        end
        if (sup) return v ? RES_VIRT : RES_ILL;
        if (tw) return RES_ILL;
        return v ? RES_VIRT : RES_HALT;
      end
      1: begin
        if (pr == 0) return RES_ILL;
        if (pr == 1 && tvm) return RES_ILL;
        if (hyp && v && vtvm) return RES_VIRT;
        return RES_FLUSH;
      end
      2: return hvRule(pr, v);
      3: begin
        if (pr == 1 && !v && tvm) return RES_ILL;
        return hvRule(pr, v);
      end
      default: return RES_ILL;
    endcase
  endfunction

  function automatic string tagFor(int op, int res);
    case (op)
      0: return (res == RES_ILL) ? "R3" : (res == RES_VIRT) ? "R4" : "R5";
      1: return "R6";
      2: return "R7";
      3: return "R8";
      4: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic drive(bit val, int op, int pr, bit v, bit sup, bit hyp,
                       bit tw, bit tvm, bit vtw, bit vtvm);
    @(negedge clk);
    reqValid = val; reqOp = 3'(op); curPriv = 2'(pr); virtMode = v;
    hasSup = sup; hasHyp = hyp; statTw = tw; statTvm = tvm;
    statVtw = vtw; statVtvm = vtvm;
    #1;
  endtask

  task automatic compare(string tag, int res);
    logic [7:0] expv, actv;
    expv = {res == RES_HALT, res == RES_FLUSH, res == RES_ILL || res == RES_VIRT,
            (res == RES_ILL) ? 5'd2 : (res == RES_VIRT) ? 5'd22 : 5'd0};
    actv = {doHalt, doFlush, raiseExc, excCause};
    checks++;
    if (actv !== expv) begin
      errors++;
      $display("FAIL %s op=%0d priv=%0d: halt/flush/exc/cause actual=%b expected=%b",
               tag, reqOp, curPriv, actv, expv);
    end
    // R2: exclusivity and cause consistency
    checks++;
    if ($countones({doHalt, doFlush, raiseExc}) > 1 || (!raiseExc && excCause != 0)) begin
      errors++;
      $display("FAIL R2: outcomes actual=%b cause=%0d expected at most one, cause 0 when idle",
               {doHalt, doFlush, raiseExc}, excCause);
    end
  endtask

  initial begin
    rstN = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    #1;
    compare("R1 reset", 0);
    rstN = 1'b1;

    // directed corner cases
    drive(1, 0, 3, 1, 1, 1, 1, 1, 1, 1); compare("R5 machine wait", RES_HALT);
    drive(1, 0, 1, 1, 1, 1, 1, 1, 1, 0); compare("R3 illegal beats virtual", RES_ILL);
    drive(1, 0, 0, 1, 1, 1, 1, 0, 0, 0); compare("R4 virt user wait", RES_VIRT);
    drive(1, 1, 1, 1, 1, 1, 0, 0, 0, 1); compare("R6 vtvm", RES_VIRT);
    drive(1, 3, 1, 0, 1, 1, 0, 1, 0, 0); compare("R8 tvm", RES_ILL);
    drive(1, 4, 3, 0, 1, 1, 0, 0, 0, 0); compare("R9 seed machine", RES_ILL);
    drive(1, 6, 3, 0, 1, 1, 0, 0, 0, 0); compare("R10 unused op", RES_ILL);

    // exhaustive sweep against the reference model
    for (int code = 0; code < 8192; code++) begin
      logic [12:0] b;
      int op, pr, res;
      b = 13'(code);
      op = int'(b[12:10]);
      pr = int'(b[9:8]);
      res = refModel(op, pr, b[7], b[6], b[5], b[4], b[3], b[2], b[1]);
      drive(1, op, pr, b[7], b[6], b[5], b[4], b[3], b[2], b[1]);
      compare(tagFor(op, res), res);
    end

    // R1: no request, any other inputs
    for (int code = 0; code < 256; code++) begin
      logic [7:0] b;
      b = 8'(code * 37 + 11);
      drive(0, int'(b[2:0]), int'(b[4:3]), b[5], b[6], b[7], b[0], b[1], b[2], b[3]);
      compare("R1 idle", 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule